// File: doc/BRIEF.md
# Wide Register Write Collector

This block sits between a host register bus that carries 32-bit or 64-bit writes and a bank of 128-bit control registers, plain 32-bit registers and 64-bit SRAM words. Wide targets cannot be written in a single bus beat. The block therefore gathers the partial writes in a collector, which holds one 128-bit line, a line tag and a per-dword valid mask. When the target word is complete, the block issues one full-width commit on its commit port.

The per-queue descriptor-pointer registers are write-only and follow relaxed rules, so the host needs no lock around them. A write that reaches their top dword always commits. Any part of the register the collector has not filled completely is sent as zero. A write to one of their lower dwords is thrown away if the collector is busy with a different line. Writes to plain 32-bit registers go straight to the commit port and leave the collector untouched.

Address classes are fixed by parameter. The upper half of the address space (top address bit set) is SRAM. Below it, the space is divided into pages of 0x2000 bytes. In each page, the lines at offsets 0x830 and 0xA10 are descriptor pointers. Lines below offset 0x400 are ordinary 128-bit registers. Everything else in a page is a plain 32-bit register.

Top module: `wide_write_collector`

## Requirements
- R1: While reset is held and after its release, the commit strobe is low and the commit data is zero until a write arrives.
- R2: An ordinary 128-bit register commits once all four dwords of its line are valid, in any write order. The commit carries the merged data (dword n in bits 32n+31:32n, dword n at byte offset 4n) and the line address (low four bits zero). Every commit clears the valid mask.
- R3: A 64-bit write (`wr_qword` high, 8-byte aligned) fills two dwords at once. `wr_data[31:0]` goes to the lower dword and `wr_data[63:32]` to the upper one.
- R4: A write to an ordinary register in a line other than the tagged one restarts the collector. Only the dwords just written are valid, and earlier partial data is lost.
- R5: A write with the top address bit set targets SRAM. A 64-bit SRAM word commits once both of its dwords are valid. The commit address is 8-byte aligned, the word is in bits 63:0 and bits 127:64 are zero.
- R6: A write covering the top dword (bits 127:96) of a descriptor-pointer register always commits that register. If the collector plus this write cover the whole line, the full merged value is committed.
- R7: When a top-dword descriptor commit does not cover the whole line, bits 95:0 of the commit are zero.
- R8: A write to a lower dword of a descriptor-pointer register, while the collector holds valid data for a different line, produces no commit and leaves the collector unchanged.
- R9: Descriptor-pointer registers sit at page offsets 0x830 and 0xA10 in every 0x2000-byte page. The same offsets shifted by half a page are plain registers.
- R10: A write to a plain register commits on the next cycle with its own address and its data zero-extended. The collector contents are not changed.
- R11: A commit raises the strobe for one cycle, in the cycle after the completing write. A write is accepted on every cycle with no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Host write present this cycle |
| wr_addr | input | ADDR_W | Host byte address |
| wr_data | input | 64 | Write data; bits 31:0 only for 32-bit writes |
| wr_qword | input | 1 | 64-bit write covering two dwords |
| cm_valid | output | 1 | One-cycle commit strobe |
| cm_addr | output | ADDR_W | Byte address of the committed target |
| cm_data | output | 128 | Committed value |

## Verification
Ordinary registers are filled with four dwords out of order, with two 64-bit halves, and with a line restart in the middle. These patterns separate correct merging, correct handling of lane pairs and correct discarding of stale partial data. A second pass over a line just committed shows that the mask was cleared. Descriptor pointers get a full fill followed by the top dword, a lone top dword, a partial fill followed by the top dword, and a top-half 64-bit write. Together these separate the full-value path from the zero-fill path. Lower-dword writes dropped against a busy collector, and plain writes placed inside a pending fill, are each followed by completion of the original line, which shows that the collector was left unchanged.

// File: rtl/wwc_pkg.sv
package wwc_pkg;
    typedef enum logic [1:0] {
        CLS_PLAIN = 2'd0,
        CLS_WIDE  = 2'd1,
        CLS_DESC  = 2'd2,
        CLS_SRAM  = 2'd3
    } wr_class_e;
endpackage

// File: rtl/wwc_decode.sv
module wwc_decode #(
    parameter int ADDR_W     = 20,
    parameter int PAGE_BYTES = 'h2000,
    parameter int DESC_OFF_A = 'h830,
    parameter int DESC_OFF_B = 'hA10,
    parameter int WIDE_END   = 'h400
) (
    input  logic [ADDR_W-5:0]       line_addr,
    output wwc_pkg::wr_class_e      cls
);
    localparam int PG_BITS = $clog2(PAGE_BYTES);
    localparam int OFF_W   = PG_BITS - 4;
    localparam logic [OFF_W-1:0] LINE_A   = OFF_W'(DESC_OFF_A >> 4);
    localparam logic [OFF_W-1:0] LINE_B   = OFF_W'(DESC_OFF_B >> 4);
    localparam logic [OFF_W-1:0] LINE_END = OFF_W'(WIDE_END >> 4);

    logic [OFF_W-1:0] off_line;
    logic             in_sram;
    logic             unused_page;

    assign off_line    = line_addr[OFF_W-1:0];
    assign in_sram     = line_addr[ADDR_W-5];
    assign unused_page = ^line_addr[ADDR_W-6:OFF_W];

    always_comb begin
        if (in_sram)
            cls = wwc_pkg::CLS_SRAM;
        else if (off_line == LINE_A || off_line == LINE_B)
            cls = wwc_pkg::CLS_DESC;
        else if (off_line < LINE_END)
            cls = wwc_pkg::CLS_WIDE;
        else
            cls = wwc_pkg::CLS_PLAIN;
    end
endmodule

// File: rtl/wwc_lane_merge.sv
module wwc_lane_merge #(
    parameter int DW    = 32,
    parameter int LANES = 4
) (
    input  logic [LANES*DW-1:0]       old_data,
    input  logic [LANES-1:0]          old_mask,
    input  logic                      restart,
    input  logic [$clog2(LANES)-1:0]  idx,
    input  logic                      qword,
    input  logic [2*DW-1:0]           wdata,
    output logic [LANES-1:0]          wmask,
    output logic [LANES*DW-1:0]       mdata,
    output logic [LANES-1:0]          mmask
);
    localparam int IDX_W = $clog2(LANES);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam logic [IDX_W-1:0] LANE_IDX = IDX_W'(i);
        logic [DW-1:0] lane_val;
        logic          pair_hit;

        assign pair_hit  = (LANE_IDX >> 1) == (idx >> 1);
        assign wmask[i]  = qword ? pair_hit : (LANE_IDX == idx);
        assign lane_val  = (qword && (i % 2 == 1)) ? wdata[2*DW-1:DW] : wdata[DW-1:0];
        assign mdata[i*DW +: DW] = wmask[i] ? lane_val : old_data[i*DW +: DW];
        assign mmask[i]  = wmask[i] | (old_mask[i] & ~restart);
    end
endmodule

// File: rtl/wide_write_collector.sv
module wide_write_collector #(
    parameter int ADDR_W     = 20,
    parameter int DW         = 32,
    parameter int PAGE_BYTES = 'h2000,
    parameter int DESC_OFF_A = 'h830,
    parameter int DESC_OFF_B = 'hA10,
    parameter int WIDE_END   = 'h400
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_valid,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [2*DW-1:0]      wr_data,
    input  logic                 wr_qword,
    output logic                 cm_valid,
    output logic [ADDR_W-1:0]    cm_addr,
    output logic [4*DW-1:0]      cm_data
);
    localparam int LANES  = 4;
    localparam int IDX_W  = $clog2(LANES);
    localparam int HOST_W = 2 * DW;
    localparam int REG_W  = LANES * DW;
    localparam int TAG_W  = ADDR_W - 4;
    localparam int HALF   = LANES / 2;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [LANES-1:0]  mask;
        logic [REG_W-1:0]  data;
        logic              cm_valid;
        logic [ADDR_W-1:0] cm_addr;
        logic [REG_W-1:0]  cm_data;
    } state_t;

    state_t st_q, st_d;

    wwc_pkg::wr_class_e cls;
    logic [TAG_W-1:0]   wtag;
    logic [IDX_W-1:0]   idx;
    logic               restart;
    logic [LANES-1:0]   wmask, mmask;
    logic [REG_W-1:0]   mdata;
    logic [HALF-1:0]    half_mask;

    assign wtag    = wr_addr[ADDR_W-1:4];
    assign idx     = wr_addr[3:2];
    assign restart = (st_q.tag != wtag);

    wwc_decode #(
        .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES),
        .DESC_OFF_A(DESC_OFF_A), .DESC_OFF_B(DESC_OFF_B), .WIDE_END(WIDE_END)
    ) u_decode (
        .line_addr (wtag),
        .cls       (cls)
    );

    wwc_lane_merge #(.DW(DW), .LANES(LANES)) u_merge (
        .old_data (st_q.data),
        .old_mask (st_q.mask),
        .restart  (restart),
        .idx      (idx),
        .qword    (wr_qword),
        .wdata    (wr_data),
        .wmask    (wmask),
        .mdata    (mdata),
        .mmask    (mmask)
    );

    assign half_mask = wr_addr[3] ? mmask[LANES-1:HALF] : mmask[HALF-1:0];

    always_comb begin
        st_d          = st_q;
        st_d.cm_valid = 1'b0;
        if (wr_valid) begin
            unique case (cls)
                wwc_pkg::CLS_PLAIN: begin
                    st_d.cm_valid = 1'b1;
                    st_d.cm_addr  = wr_addr;
                    st_d.cm_data  = {{(REG_W-HOST_W){1'b0}},
                                     wr_qword ? wr_data : {{DW{1'b0}}, wr_data[DW-1:0]}};
                end
                wwc_pkg::CLS_WIDE: begin
                    if (&mmask) begin
                        st_d.cm_valid = 1'b1;
                        st_d.cm_addr  = {wtag, 4'b0};
                        st_d.cm_data  = mdata;
                        st_d.mask     = '0;
                    end else begin
                        st_d.tag  = wtag;
                        st_d.data = mdata;
                        st_d.mask = mmask;
                    end
                end
                wwc_pkg::CLS_SRAM: begin
                    if (&half_mask) begin
                        st_d.cm_valid = 1'b1;
                        st_d.cm_addr  = {wtag, wr_addr[3], 3'b0};
                        st_d.cm_data  = {{(REG_W-HOST_W){1'b0}},
                                         wr_addr[3] ? mdata[REG_W-1:HOST_W] : mdata[HOST_W-1:0]};
                        st_d.mask     = '0;
                    end else begin
                        st_d.tag  = wtag;
                        st_d.data = mdata;
                        st_d.mask = mmask;
                    end
                end
                wwc_pkg::CLS_DESC: begin
                    if (wmask[LANES-1]) begin
                        st_d.cm_valid = 1'b1;
                        st_d.cm_addr  = {wtag, 4'b0};
                        st_d.cm_data  = (&mmask) ? mdata
                                      : {mdata[REG_W-1:REG_W-DW], {(REG_W-DW){1'b0}}};
                        st_d.mask     = '0;
                    end else if (!((|st_q.mask) && restart)) begin
                        st_d.tag  = wtag;
                        st_d.data = mdata;
                        st_d.mask = mmask;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cm_valid = st_q.cm_valid;
    assign cm_addr  = st_q.cm_addr;
    assign cm_data  = st_q.cm_data;
endmodule

// File: rtl/wwc_checker.sv
module wwc_checker #(
    parameter int ADDR_W = 20
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_valid,
    input logic [ADDR_W-1:0]    wr_addr,
    input logic                 wr_qword,
    input logic                 cm_valid,
    input logic [ADDR_W-1:0]    cm_addr,
    input logic [127:0]         cm_data,
    input wwc_pkg::wr_class_e   cls,
    input logic [3:0]           mask_q,
    input logic [ADDR_W-5:0]    tag_q
);
    logic top_hit;
    assign top_hit = (wr_addr[3:2] == 2'b11) || (wr_qword && wr_addr[3]);

    // R10
    plain_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && cls == wwc_pkg::CLS_PLAIN |=> cm_valid && cm_addr == $past(wr_addr));

    // R10
    plain_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && cls == wwc_pkg::CLS_PLAIN |=> $stable(mask_q) && $stable(tag_q));

    // R6
    desc_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && cls == wwc_pkg::CLS_DESC && top_hit |=> cm_valid && cm_addr[3:0] == 4'h0);

    // R8
    desc_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && cls == wwc_pkg::CLS_DESC && !top_hit && mask_q != 4'h0
        && tag_q != wr_addr[ADDR_W-1:4] |=> !cm_valid && $stable(mask_q) && $stable(tag_q));

    // R5
    sram_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cm_valid && $past(wr_valid && cls == wwc_pkg::CLS_SRAM)
        |-> cm_data[127:64] == 64'h0 && cm_addr[2:0] == 3'h0);

    // R2
    commit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cm_valid && $past(wr_valid && cls != wwc_pkg::CLS_PLAIN) |-> mask_q == 4'h0);

    // R11
    commit_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cm_valid |-> $past(wr_valid));
endmodule

bind wide_write_collector wwc_checker #(.ADDR_W(ADDR_W)) u_wwc_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .wr_addr  (wr_addr),
    .wr_qword (wr_qword),
    .cm_valid (cm_valid),
    .cm_addr  (cm_addr),
    .cm_data  (cm_data),
    .cls      (cls),
    .mask_q   (st_q.mask),
    .tag_q    (st_q.tag)
);

// File: tb/test_wide_write_collector.sv
`timescale 1ns/1ps
module test_wide_write_collector;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_valid = 1'b0;
    logic [19:0]  wr_addr = '0;
    logic [63:0]  wr_data = '0;
    logic         wr_qword = 1'b0;
    logic         cm_valid;
    logic [19:0]  cm_addr;
    logic [127:0] cm_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    wide_write_collector i_wide_write_collector (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_qword(wr_qword),
        .cm_valid(cm_valid), .cm_addr(cm_addr), .cm_data(cm_data)
    );

    typedef struct packed {
        logic [19:0]  addr;
        logic [63:0]  data;
        logic         qw;
        logic         ecv;
        logic [19:0]  eaddr;
        logic [127:0] edata;
        logic [3:0]   req;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t TBL [NV] = '{
        '{20'h00100, 64'hA000_0000, 1'b0, 1'b0, 20'h0, 128'h0, 4'd2},
        '{20'h00108, 64'hA000_0002, 1'b0, 1'b0, 20'h0, 128'h0, 4'd2},
        '{20'h0010C, 64'hA000_0003, 1'b0, 1'b0, 20'h0, 128'h0, 4'd2},
        '{20'h00104, 64'hA000_0001, 1'b0, 1'b1, 20'h00100,
          128'hA0000003_A0000002_A0000001_A0000000, 4'd2},
        '{20'h00200, 64'hB000_0001_B000_0000, 1'b1, 1'b0, 20'h0, 128'h0, 4'd3},
        '{20'h00208, 64'hB000_0003_B000_0002, 1'b1, 1'b1, 20'h00200,
          128'hB0000003_B0000002_B0000001_B0000000, 4'd3},
        '{20'h00200, 64'hC000_0001_C000_0000, 1'b1, 1'b0, 20'h0, 128'h0, 4'd2},
        '{20'h00310, 64'hD000_0000, 1'b0, 1'b0, 20'h0, 128'h0, 4'd4},
        '{20'h00314, 64'hD000_0001, 1'b0, 1'b0, 20'h0, 128'h0, 4'd4},
        '{20'h00318, 64'hD000_0003_D000_0002, 1'b1, 1'b1, 20'h00310,
          128'hD0000003_D0000002_D0000001_D0000000, 4'd4},
        '{20'h00208, 64'hC000_0003_C000_0002, 1'b1, 1'b0, 20'h0, 128'h0, 4'd4}
    };

    function automatic string rname(input logic [3:0] r);
        case (r)
            4'd2:    return "R2";
            4'd3:    return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic chk(input string req, input logic ecv,
                       input logic [19:0] ea, input logic [127:0] ed);
        checks++;
        if (cm_valid !== ecv || (ecv && (cm_addr !== ea || cm_data !== ed))) begin
            errors++;
            $display("FAIL %s: got v=%0b a=%h d=%h expected v=%0b a=%h d=%h",
                     req, cm_valid, cm_addr, cm_data, ecv, ea, ed);
        end
    endtask

    task automatic wr(input logic [19:0] a, input logic [63:0] d, input logic qw);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_addr  = a;
        wr_data  = d;
        wr_qword = qw;
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        wr_valid = 1'b0;
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1", 1'b0, 20'h0, 128'h0);
        checks++;
        if (cm_data !== 128'h0) begin
            errors++;
            $display("FAIL R1: got d=%h expected d=0", cm_data);
        end
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk("R1", 1'b0, 20'h0, 128'h0);

        // R2 R3 R4: ordinary register table
        for (int i = 0; i < NV; i++) begin
            wr(TBL[i].addr, TBL[i].data, TBL[i].qw);
            chk(rname(TBL[i].req), TBL[i].ecv, TBL[i].eaddr, TBL[i].edata);
        end

        // R5: SRAM halves and a single 64-bit write
        wr(20'h80008, 64'h5000_0000, 1'b0);
        chk("R5", 1'b0, 20'h0, 128'h0);
        wr(20'h8000C, 64'h5000_0001, 1'b0);
        chk("R5", 1'b1, 20'h80008, {64'h0, 64'h5000_0001_5000_0000});
        wr(20'h80010, 64'h5100_0001_5100_0000, 1'b1);
        chk("R5", 1'b1, 20'h80010, {64'h0, 64'h5100_0001_5100_0000});
        idle();
        chk("R11", 1'b0, 20'h0, 128'h0);

        // R6 R9: full descriptor fill in page 3
        wr(20'h06830, 64'hE000_0000, 1'b0);
        chk("R6", 1'b0, 20'h0, 128'h0);
        wr(20'h06834, 64'hE000_0001, 1'b0);
        wr(20'h06838, 64'hE000_0002, 1'b0);
        chk("R6", 1'b0, 20'h0, 128'h0);
        wr(20'h0683C, 64'hE000_0003, 1'b0);
        chk("R9", 1'b1, 20'h06830, 128'hE0000003_E0000002_E0000001_E0000000);

        // R7: lone top dword, partial then top, top-half qword
        wr(20'h06A1C, 64'hF000_0003, 1'b0);
        chk("R7", 1'b1, 20'h06A10, {32'hF000_0003, 96'h0});
        wr(20'h06A10, 64'h6000_0000, 1'b0);
        chk("R7", 1'b0, 20'h0, 128'h0);
        wr(20'h06A1C, 64'h6000_0003, 1'b0);
        chk("R7", 1'b1, 20'h06A10, {32'h6000_0003, 96'h0});
        wr(20'h06838, 64'h7000_0003_7000_0002, 1'b1);
        chk("R7", 1'b1, 20'h06830, {32'h7000_0003, 96'h0});

        // R9: page 0 descriptor vs half-page offset (plain)
        wr(20'h00A1C, 64'h7100_0003, 1'b0);
        chk("R9", 1'b1, 20'h00A10, {32'h7100_0003, 96'h0});
        wr(20'h01A1C, 64'h7200_0003, 1'b0);
        chk("R9", 1'b1, 20'h01A1C, {96'h0, 32'h7200_0003});

        // R8: lower descriptor dword dropped against a busy collector
        wr(20'h00100, 64'h8000_0000, 1'b0);
        wr(20'h06834, 64'hDEAD_BEEF, 1'b0);
        chk("R8", 1'b0, 20'h0, 128'h0);
        wr(20'h00104, 64'h8000_0001, 1'b0);
        wr(20'h00108, 64'h8000_0002, 1'b0);
        wr(20'h0010C, 64'h8000_0003, 1'b0);
        chk("R8", 1'b1, 20'h00100, 128'h80000003_80000002_80000001_80000000);

        // R10: plain write inside a pending fill
        wr(20'h00100, 64'h9000_0000, 1'b0);
        wr(20'h00420, 64'h1234_5678_9ABC_DEF0, 1'b0);
        chk("R10", 1'b1, 20'h00420, {96'h0, 32'h9ABC_DEF0});
        wr(20'h00104, 64'h9000_0001, 1'b0);
        chk("R11", 1'b0, 20'h0, 128'h0);
        wr(20'h00108, 64'h9000_0002, 1'b0);
        wr(20'h0010C, 64'h9000_0003, 1'b0);
        chk("R10", 1'b1, 20'h00100, 128'h90000003_90000002_90000001_90000000);
        idle();
        chk("R11", 1'b0, 20'h0, 128'h0);

        finish_run();
    end
endmodule